// File: doc/BRIEF.md
# Character LCD Scan Generator

This block refreshes a small character display without any help from the host. It walks the common (row) lines one at a time. During each row period it visits every visible character position and computes that position's address in display memory from the current shift offset. It reads the character code through a read port. The code then selects a five-dot pattern row, either from the writable glyph RAM (codes whose upper nibble is zero) or from the fixed glyph ROM. The cursor and blink overlays are applied next, and the dots are shifted one per clock into a segment shift register.

At the end of a row the shift register is copied into the segment output latch. In the same cycle the matching common line becomes the single active one. The number of commons scanned depends on the line and font mode. Blinking alternates on a frame count, with the length of each half set by a parameter. All memory reads are combinational: an address leaves the block and the data returns in the same cycle.

Top module: `lcd_scan`

## Requirements
- R1: While reset is asserted, every common output and every segment output is 0.
- R2: With `two_line`=0 and `tall_font`=0, the commons are activated in the order 0,1,...,7 and then repeat. With `two_line`=0 and `tall_font`=1 the order runs 0..10. With `two_line`=1 it runs 0..15. At most one common is high at any time, and a common above the current mode's range is never high.
- R3: Each row step lasts NUM_SEG+1 clock cycles: one cycle per segment dot plus one latch cycle. The segment latch and the active common change on the same edge.
- R4: In one-line mode, visible position k (0..7) shows display address (k + shift_ofs) mod 80, for offsets 0..79. Offset 1 therefore shows 0x01..0x08, and offset 79 starts with 0x4F.
- R5: In two-line mode, rows 0..7 show line 1 at addresses (k + shift_ofs) mod 40, and rows 8..15 show line 2 at 0x40 + ((k + shift_ofs) mod 40). Each line wraps within its own 40 addresses.
- R6: A code with bits 7..4 equal to zero reads the glyph RAM, and code bit 3 is ignored (0x00 and 0x08 look the same). The RAM address is {code[2:0], row[2:0]} for the 8-row font and {code[2:1], row[3:0]} for the 11-row font. The glyph RAM returns pattern bits 4..0 only.
- R7: Any other code reads the glyph ROM at address {code[7:0], row[3:0]}, which returns 5 pattern bits.
- R8: Segment 5k+j (segment 0 is leftmost) carries bit 4-j of the pattern row of visible character k, and a 1 lights the dot.
- R9: With `cursor_on`=1, the character whose display address equals `cursor_addr` has all five dots lit on its bottom pattern row: row 7 for the 8-row font, row 10 for the 11-row font.
- R10: With `blink_on`=1, the blink phase starts normal after reset and toggles every BLINK_HALF frames. While the phase is set, every row of the cursor character is fully lit.
- R11: With `disp_on`=0, all segments are 0 while the commons keep scanning.
- R12: With `two_line`=1, the 8-row font is used and `tall_font` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| two_line | input | 1 | 1 selects the two-line layout |
| tall_font | input | 1 | 1 selects the 11-row font (one-line only) |
| disp_on | input | 1 | Display enable |
| cursor_on | input | 1 | Underline cursor enable |
| blink_on | input | 1 | Cursor cell blink enable |
| cursor_addr | input | 7 | Display address that holds the cursor |
| shift_ofs | input | 7 | Display shift offset (left shifts) |
| dd_addr | output | 7 | Display memory read address |
| dd_data | input | 8 | Character code read from display memory |
| cg_addr | output | 6 | Glyph RAM read address |
| cg_data | input | 5 | Glyph RAM pattern row |
| rom_addr | output | 12 | Glyph ROM read address |
| rom_data | input | 5 | Glyph ROM pattern row |
| seg | output | NUM_SEG | Latched segment dots, bit 0 leftmost |
| com | output | NUM_COM | One-hot active common |

## Verification
The offset is swept across all 80 values in one-line mode and all 40 in two-line mode. This separates a single modulo-80 wrap from two independent modulo-40 wraps with the 0x40 base on the second line. The display memory holds a mix of glyph-RAM codes (including the aliasing pair 0x00/0x08) and ROM codes, with junk in the upper glyph-RAM bits. Every latched row is therefore checked for source selection, address packing and column order together. Runs with the 11-row font, with two-line mode plus `tall_font`, with the cursor on different lines, with blink over six frames, and with the display off separate the duty lengths, the cursor row, the phase timing and the blanking.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

  localparam int GLYPH_W = 5;

  typedef enum logic [1:0] {
    DUTY_8  = 2'd0,
    DUTY_11 = 2'd1,
    DUTY_16 = 2'd2
  } duty_e;

  function automatic duty_e mode_duty(input logic two_line, input logic tall_font);
    if (two_line)       return DUTY_16;
    else if (tall_font) return DUTY_11;
    else                return DUTY_8;
  endfunction

  function automatic logic [4:0] duty_rows(input duty_e d);
    case (d)
      DUTY_11: return 5'd11;
      DUTY_16: return 5'd16;
      default: return 5'd8;
    endcase
  endfunction

  function automatic logic [3:0] cursor_row(input logic tall);
    return tall ? 4'd10 : 4'd7;
  endfunction

endpackage

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG    = 40,
  parameter int NUM_COM    = 16,
  parameter int BLINK_HALF = 16,
  localparam int CHR_W = $clog2(NUM_SEG / GLYPH_W),
  localparam int ROW_W = $clog2(NUM_COM)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  duty_e            duty,
  output logic [2:0]       col,
  output logic [CHR_W-1:0] chr,
  output logic [ROW_W-1:0] row,
  output logic             shift_en,
  output logic             latch,
  output logic             row_ok,
  output logic             blink_phase
);

  localparam int BIT_W = $clog2(NUM_SEG + 1);
  localparam int FR_W  = (BLINK_HALF > 1) ? $clog2(BLINK_HALF) : 1;

  logic [BIT_W-1:0] bit_q, bit_d;
  logic [2:0]       col_q, col_d;
  logic [CHR_W-1:0] chr_q, chr_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [FR_W-1:0]  fr_q, fr_d;
  logic             ph_q, ph_d;
  logic [4:0]       rows;
  logic             row_last;

  assign rows     = duty_rows(duty);
  assign latch    = (bit_q == BIT_W'(NUM_SEG));
  assign shift_en = ~latch;
  assign row_ok   = ({1'b0, row_q} < rows);
  assign row_last = ({1'b0, row_q} >= (rows - 5'd1));

  always_comb begin
    bit_d = bit_q;
    col_d = col_q;
    chr_d = chr_q;
    row_d = row_q;
    fr_d  = fr_q;
    ph_d  = ph_q;
    if (latch) begin
      bit_d = '0;
      col_d = '0;
      chr_d = '0;
      if (row_last) begin
        row_d = '0;
        if (fr_q == FR_W'(BLINK_HALF - 1)) begin
          fr_d = '0;
          ph_d = ~ph_q;
        end else begin
          fr_d = fr_q + FR_W'(1);
        end
      end else begin
        row_d = row_q + ROW_W'(1);
      end
    end else begin
      bit_d = bit_q + BIT_W'(1);
      if (col_q == 3'd4) begin
        col_d = '0;
        chr_d = chr_q + CHR_W'(1);
      end else begin
        col_d = col_q + 3'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= '0;
      col_q <= '0;
      chr_q <= '0;
      row_q <= '0;
      fr_q  <= '0;
      ph_q  <= 1'b0;
    end else begin
      bit_q <= bit_d;
      col_q <= col_d;
      chr_q <= chr_d;
      row_q <= row_d;
      fr_q  <= fr_d;
      ph_q  <= ph_d;
    end
  end

  assign col         = col_q;
  assign chr         = chr_q;
  assign row         = row_q;
  assign blink_phase = ph_q;

endmodule

// File: rtl/lcd_scan_fetch.sv
module lcd_scan_fetch
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG    = 40,
  parameter int NUM_COM    = 16,
  parameter int LINE_LEN   = 40,
  parameter int ADDR_W     = 7,
  parameter int LINE2_BASE = 64,
  localparam int CHR_W = $clog2(NUM_SEG / GLYPH_W),
  localparam int ROW_W = $clog2(NUM_COM)
) (
  input  logic               two_line,
  input  logic               tall_font,
  input  logic               disp_on,
  input  logic               cursor_on,
  input  logic               blink_on,
  input  logic               blink_phase,
  input  logic [ADDR_W-1:0]  cursor_addr,
  input  logic [ADDR_W-1:0]  shift_ofs,
  input  logic [CHR_W-1:0]   chr,
  input  logic [2:0]         col,
  input  logic [ROW_W-1:0]   row,
  output logic [ADDR_W-1:0]  dd_addr,
  input  logic [7:0]         dd_data,
  output logic [5:0]         cg_addr,
  input  logic [GLYPH_W-1:0] cg_data,
  output logic [11:0]        rom_addr,
  input  logic [GLYPH_W-1:0] rom_data,
  output logic               dot
);

  localparam int SW = ADDR_W + 1;

  logic               eff_tall, line2, cg_sel, at_cur, bottom, pix;
  logic [ROW_W-1:0]   prow;
  logic [SW-1:0]      span, ofs_w, ofs_m, sum, pos;
  logic [GLYPH_W-1:0] pat;

  // Address of the visible position: each layout wraps on its own span.
  always_comb begin
    eff_tall = tall_font & ~two_line;
    line2    = two_line & row[3];
    prow     = two_line ? ROW_W'(row[2:0]) : row;
    span     = two_line ? SW'(LINE_LEN) : SW'(2 * LINE_LEN);
    ofs_w    = SW'(shift_ofs);
    ofs_m    = (ofs_w >= span) ? (ofs_w - span) : ofs_w;
    sum      = ofs_m + SW'(chr);
    pos      = (sum >= span) ? (sum - span) : sum;
    dd_addr  = ADDR_W'(pos + (line2 ? SW'(LINE2_BASE) : SW'(0)));
  end

  // Glyph source and pattern row.
  always_comb begin
    cg_sel   = (dd_data[7:4] == 4'd0);
    cg_addr  = eff_tall ? {dd_data[2:1], prow[3:0]} : {dd_data[2:0], prow[2:0]};
    rom_addr = {dd_data, prow[3:0]};
    pat      = cg_sel ? cg_data : rom_data;
    pix      = pat[3'd4 - col];
  end

  // Cursor underline, blink fill and display gate.
  always_comb begin
    at_cur = (dd_addr == cursor_addr);
    bottom = (prow == ROW_W'(cursor_row(eff_tall)));
    dot    = disp_on & (pix | (at_cur & cursor_on & bottom)
                            | (at_cur & blink_on & blink_phase));
  end

endmodule

// File: rtl/lcd_scan_out.sv
module lcd_scan_out #(
  parameter int NUM_SEG = 40,
  parameter int NUM_COM = 16,
  localparam int ROW_W = $clog2(NUM_COM)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               latch,
  input  logic               dot,
  input  logic               row_ok,
  input  logic [ROW_W-1:0]   row,
  output logic [NUM_SEG-1:0] seg,
  output logic [NUM_COM-1:0] com
);

  logic [NUM_SEG-1:0] sreg_q, sreg_d;
  logic [NUM_SEG-1:0] seg_q;
  logic [NUM_COM-1:0] com_q, com_hit;

  // First dot shifted in ends up in bit 0 (leftmost segment).
  assign sreg_d = {dot, sreg_q[NUM_SEG-1:1]};

  for (genvar k = 0; k < NUM_COM; k++) begin : g_com
    assign com_hit[k] = row_ok && (row == ROW_W'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
    end else if (shift_en) begin
      sreg_q <= sreg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seg_q <= '0;
      com_q <= '0;
    end else if (latch) begin
      seg_q <= sreg_q;
      com_q <= com_hit;
    end
  end

  assign seg = seg_q;
  assign com = com_q;

endmodule

// File: rtl/lcd_scan.sv
module lcd_scan
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG    = 40,
  parameter int NUM_COM    = 16,
  parameter int LINE_LEN   = 40,
  parameter int BLINK_HALF = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               two_line,
  input  logic               tall_font,
  input  logic               disp_on,
  input  logic               cursor_on,
  input  logic               blink_on,
  input  logic [6:0]         cursor_addr,
  input  logic [6:0]         shift_ofs,
  output logic [6:0]         dd_addr,
  input  logic [7:0]         dd_data,
  output logic [5:0]         cg_addr,
  input  logic [4:0]         cg_data,
  output logic [11:0]        rom_addr,
  input  logic [4:0]         rom_data,
  output logic [NUM_SEG-1:0] seg,
  output logic [NUM_COM-1:0] com
);

  localparam int CHR_W = $clog2(NUM_SEG / GLYPH_W);
  localparam int ROW_W = $clog2(NUM_COM);

  logic [1:0]       rst_sync;
  logic             rst_core_n;
  logic [2:0]       col;
  logic [CHR_W-1:0] chr;
  logic [ROW_W-1:0] row;
  logic             shift_en, latch, row_ok, blink_phase, dot;
  duty_e            duty;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  assign duty = mode_duty(two_line, tall_font);

  lcd_scan_timer #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .BLINK_HALF(BLINK_HALF)
  ) u_timer (
    .clk(clk), .rst_n(rst_core_n), .duty(duty),
    .col(col), .chr(chr), .row(row),
    .shift_en(shift_en), .latch(latch), .row_ok(row_ok),
    .blink_phase(blink_phase)
  );

  lcd_scan_fetch #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM), .LINE_LEN(LINE_LEN),
    .ADDR_W(7), .LINE2_BASE(64)
  ) u_fetch (
    .two_line(two_line), .tall_font(tall_font), .disp_on(disp_on),
    .cursor_on(cursor_on), .blink_on(blink_on), .blink_phase(blink_phase),
    .cursor_addr(cursor_addr), .shift_ofs(shift_ofs),
    .chr(chr), .col(col), .row(row),
    .dd_addr(dd_addr), .dd_data(dd_data),
    .cg_addr(cg_addr), .cg_data(cg_data),
    .rom_addr(rom_addr), .rom_data(rom_data),
    .dot(dot)
  );

  lcd_scan_out #(
    .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)
  ) u_out (
    .clk(clk), .rst_n(rst_core_n), .shift_en(shift_en), .latch(latch),
    .dot(dot), .row_ok(row_ok), .row(row), .seg(seg), .com(com)
  );

endmodule

// File: rtl/lcd_scan_checker.sv
module lcd_scan_checker
  import lcd_scan_pkg::*;
#(
  parameter int NUM_SEG = 40,
  parameter int NUM_COM = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               two_line,
  input logic               tall_font,
  input logic               disp_on,
  input logic [11:0]        rom_addr,
  input logic [NUM_SEG-1:0] seg,
  input logic [NUM_COM-1:0] com
);

  localparam int OFF_LIM = 2 * (NUM_SEG + 1);

  logic [NUM_COM-1:0] com_q;
  logic [4:0]         rows_q;
  logic [15:0]        gap_cnt;
  logic [15:0]        off_cnt;
  logic               seen;
  logic               com_moved;

  assign com_moved = (com != com_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      com_q   <= '0;
      rows_q  <= 5'd8;
      gap_cnt <= '0;
      off_cnt <= '0;
      seen    <= 1'b0;
    end else begin
      com_q  <= com;
      rows_q <= duty_rows(mode_duty(two_line, tall_font));
      if (com_moved) begin
        gap_cnt <= '0;
        seen    <= 1'b1;
      end else if (gap_cnt != 16'hFFFF) begin
        gap_cnt <= gap_cnt + 16'd1;
      end
      if (disp_on)                      off_cnt <= '0;
      else if (off_cnt != 16'(OFF_LIM)) off_cnt <= off_cnt + 16'd1;
    end
  end

  AST_COM_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(com)); // R2

  AST_COM_IN_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    com_moved |-> ((com >> rows_q) == '0)); // R2

  AST_ROW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (com_moved && seen) |-> (gap_cnt == 16'(NUM_SEG))); // R3

  AST_BLANK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (off_cnt == 16'(OFF_LIM)) |-> (seg == '0)); // R11

  AST_SHORT_FONT_TWO_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    two_line |-> (rom_addr[3:0] < 4'd8)); // R12

endmodule

bind lcd_scan lcd_scan_checker #(
  .NUM_SEG(NUM_SEG), .NUM_COM(NUM_COM)
) u_lcd_scan_checker (
  .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
  .disp_on(disp_on), .rom_addr(rom_addr), .seg(seg), .com(com)
);

// File: tb/lcd_scan_test.sv
module lcd_scan_test;

  localparam int NS = 40;
  localparam int NC = 16;
  localparam int BH = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          two_line, tall_font, disp_on, cursor_on, blink_on;
  logic [6:0]    cursor_addr, shift_ofs;
  logic [6:0]    dd_addr;
  logic [7:0]    dd_data;
  logic [5:0]    cg_addr;
  logic [4:0]    cg_data;
  logic [11:0]   rom_addr;
  logic [4:0]    rom_data;
  logic [NS-1:0] seg;
  logic [NC-1:0] com;

  logic [7:0] dd_mem [128];
  logic [7:0] cg_mem [64];

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  int cfg_n, cfg_f, cfg_d, cfg_c, cfg_b, cfg_cur, cfg_ofs;

  always #4 clk = ~clk;

  function automatic logic [4:0] rom_f(input int a);
    return 5'((a * 29 + (a >> 5) + 3) % 32);
  endfunction

  assign dd_data  = dd_mem[dd_addr];
  assign cg_data  = cg_mem[cg_addr][4:0];
  assign rom_data = rom_f(int'(rom_addr));

  lcd_scan #(.NUM_SEG(NS), .NUM_COM(NC), .LINE_LEN(40), .BLINK_HALF(BH)) uut (
    .clk(clk), .rst_n(rst_n), .two_line(two_line), .tall_font(tall_font),
    .disp_on(disp_on), .cursor_on(cursor_on), .blink_on(blink_on),
    .cursor_addr(cursor_addr), .shift_ofs(shift_ofs),
    .dd_addr(dd_addr), .dd_data(dd_data), .cg_addr(cg_addr), .cg_data(cg_data),
    .rom_addr(rom_addr), .rom_data(rom_data), .seg(seg), .com(com)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected dots of one row, from the requirement formulas (R4..R12).
  function automatic logic [NS-1:0] exp_row(input int r, input int ph);
    logic [NS-1:0] res = '0;
    int tall = (cfg_f != 0 && cfg_n == 0) ? 1 : 0;   // R12
    int line = cfg_n ? r / 8 : 0;
    int prow = cfg_n ? r % 8 : r;
    for (int k = 0; k < NS / 5; k++) begin
      int a    = cfg_n ? line * 64 + (k + cfg_ofs) % 40 : (k + cfg_ofs) % 80;
      int code = int'(dd_mem[a]);
      int pat;
      if (code < 16)                                // R6
        pat = tall ? int'(cg_mem[((code / 2) % 4) * 16 + prow]) % 32
                   : int'(cg_mem[(code % 8) * 8 + prow]) % 32;
      else
        pat = int'(rom_f(code * 16 + prow));        // R7
      if (a == cfg_cur && cfg_c != 0 && prow == (tall ? 10 : 7)) pat = 31; // R9
      if (a == cfg_cur && cfg_b != 0 && ph != 0) pat = 31;                 // R10
      if (cfg_d == 0) pat = 0;                                             // R11
      for (int j = 0; j < 5; j++) res[5 * k + j] = 1'((pat >> (4 - j)) & 1); // R8
    end
    return res;
  endfunction

  task automatic run_cfg(input int n, input int f, input int d, input int c,
                         input int b, input int cur, input int ofs,
                         input int frames, input string tag);
    int rows, er, fr, cyc, last, idle;
    logic [NC-1:0] prev;
    rst_n = 1'b0;
    cfg_n = n; cfg_f = f; cfg_d = d; cfg_c = c; cfg_b = b;
    cfg_cur = cur; cfg_ofs = ofs;
    two_line = 1'(n); tall_font = 1'(f); disp_on = 1'(d);
    cursor_on = 1'(c); blink_on = 1'(b);
    cursor_addr = 7'(cur); shift_ofs = 7'(ofs);
    repeat (3) @(negedge clk);
    chk(com == '0 && seg == '0, "R1 reset", {com, seg[39:0]}, 64'd0);
    rst_n = 1'b1;
    rows = n ? 16 : (f ? 11 : 8);
    er = 0; fr = 0; cyc = 0; last = -1; idle = 0; prev = '0;
    while (fr < frames) begin
      @(negedge clk);
      cyc++; idle++;
      if (com != prev) begin
        if (last >= 0)
          chk(cyc - last == NS + 1, "R3 row period", 64'(cyc - last), 64'(NS + 1));
        chk(com == (16'(1) << er), "R2 common order", 64'(com), 64'(16'(1) << er));
        chk(seg == exp_row(er, (fr / BH) % 2), tag, 64'(seg),
            64'(exp_row(er, (fr / BH) % 2)));
        prev = com; last = cyc; idle = 0;
        er++;
        if (er == rows) begin er = 0; fr++; end
      end
      if (idle > 500) begin
        chk(1'b0, "watchdog no common step", 64'(idle), 64'(NS + 1));
        break;
      end
    end
  endtask

  initial begin
    rst_n = 1'b0;
    two_line = 0; tall_font = 0; disp_on = 0; cursor_on = 0; blink_on = 0;
    cursor_addr = '0; shift_ofs = '0;
    for (int a = 0; a < 128; a++)
      dd_mem[a] = (a % 5 == 0) ? 8'(a % 16) : 8'((a * 37 + 11) % 256);
    dd_mem[1] = 8'h00; dd_mem[2] = 8'h08;   // R6 alias pair
    dd_mem[8'h41] = 8'h05; dd_mem[8'h43] = 8'h0D;
    for (int i = 0; i < 64; i++) cg_mem[i] = 8'((i * 53 + 7) % 256);

    run_cfg(0, 0, 1, 0, 0, 127, 0, 2, "R7 R8 rom and columns");
    run_cfg(0, 0, 1, 0, 0, 127, 1, 1, "R4 left shift");
    run_cfg(0, 0, 1, 0, 0, 127, 79, 1, "R4 right shift");
    run_cfg(0, 0, 1, 0, 0, 127, 75, 1, "R4 wrap mid-line");
    run_cfg(0, 1, 1, 0, 0, 127, 3, 2, "R6 tall glyphs");
    run_cfg(0, 1, 1, 1, 0, 5, 0, 1, "R9 tall cursor");
    run_cfg(0, 0, 1, 1, 0, 3, 0, 1, "R9 cursor line1");
    run_cfg(1, 0, 1, 1, 0, 66, 0, 1, "R9 cursor line2");
    run_cfg(1, 0, 1, 0, 0, 127, 39, 1, "R5 right shift");
    run_cfg(1, 1, 1, 0, 0, 127, 2, 1, "R12 two-line ignores tall");
    run_cfg(0, 0, 1, 0, 1, 2, 0, 6, "R10 blink");
    run_cfg(0, 1, 1, 1, 1, 4, 0, 4, "R10 blink tall");
    run_cfg(0, 0, 0, 1, 1, 2, 0, 2, "R11 display off");
    run_cfg(1, 0, 0, 0, 0, 127, 0, 1, "R11 display off two-line");
    for (int o = 0; o < 80; o++) run_cfg(0, 0, 1, 1, 0, (o * 3) % 80, o, 1, "R4 sweep");
    for (int o = 0; o < 40; o++) run_cfg(1, 0, 1, 1, 0, 64 + (o * 7) % 40, o, 1, "R5 sweep");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule